// File: doc/BRIEF.md
# Reloading Alarm Countdown Timer

This block is a periodic alarm driven by a 24-bit down-counter. Software loads a seed through a byte-wide register port. While the alarm is enabled and the seed is nonzero, the live count drops by one on every cycle where the one-second tick enable is high. When the count runs out, the block reloads the seed, sets a sticky expiry flag and, if interrupts are configured, holds an active-low interrupt line low until software clears the flag.

The register port has an address, write data, a write strobe, a read strobe and registered read data. It maps three count bytes, with the least significant at 04h and the most significant at 06h. A control byte sits at 07h and a status byte at 08h. Reading the lowest count byte takes a snapshot of the live count, and the two upper bytes are then served from that snapshot, so a multi-byte read is coherent while counting goes on.

Top module: `alarm_countdown_timer`

## Requirements
- R1: A synchronous active-low reset clears the seed, live count, control byte, expiry flag, snapshot and read data. After reset every register reads 0 and int_n_o is high.
- R2: Writes to 04h, 05h and 06h store bytes 0, 1 and 2 of the seed (04h is the least significant byte) and leave the live count unchanged.
- R3: The live count decrements by one per tick only while control bit 6 (enable) is 1 and the seed is nonzero. Otherwise it holds its value.
- R4: A control write that changes bit 6 from 0 to 1 loads the seed into the live count, and no tick is taken in that cycle. A control write with bit 6 already 1 does not reload.
- R5: A tick taken while the live count is 1 (or 0) is an expiry and reloads the seed, so expiries repeat every seed ticks.
- R6: An expiry sets status bit 0 (the flag). A status write with bit 0 = 0 clears the flag and one with bit 0 = 1 leaves it alone. An expiry in the same cycle as a clearing write leaves the flag set.
- R7: int_n_o is low exactly while control bit 0 (interrupt enable), control bit 3 (interrupt mode) and the flag are all 1, and it follows them one cycle after the edge that changes them.
- R8: A read of 04h returns the low byte of the live count and captures the whole count into a snapshot. Reads of 05h and 06h return the snapshot's bytes 1 and 2.
- R9: The control byte reads back what was written, with bits 5 and 4 as 0. The status byte reads bit 7 as last written and bits 6 to 1 as 0. Control bits 7, 2 and 1 and status bit 7 have no other effect.
- R10: Read data is registered. It is valid in the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all logic |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle count enable, once per second |
| addr_i | input | ADDR_W (5) | Register address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe, one cycle per write |
| rd_i | input | 1 | Read strobe, one cycle per read |
| rdata_o | output | 8 | Registered read data |
| int_n_o | output | 1 | Active-low alarm interrupt |

## Verification
Every register the block owns changes on the clock edge that samples the strobe or tick. Read data therefore appears one edge after the read strobe, and int_n_o and the flag settle one edge after the expiring tick or the status write. The driver applies each stimulus for exactly one cycle from a falling edge. The monitor compares rdata_o at the falling edge that follows the sampling rising edge, and it pops one queued expectation per read. Direct checks on int_n_o are made at a falling edge once the driving write or tick has been taken.

// File: rtl/alarm_tmr_pkg.sv
// Package: shared constants for the alarm countdown timer.
// Assumes a byte-wide register port and the fixed map used by the block.
package alarm_tmr_pkg;
    localparam int BYTE_W      = 8;
    localparam int CNT_BASE    = 4;       // least significant count byte
    localparam int CTRL_ADDR   = 7;
    localparam int STAT_ADDR   = 8;
    localparam logic [7:0] CTRL_RW_MASK = 8'hCF;  // bits 5:4 read as 0
    localparam int EN_BIT      = 6;       // alarm enable
    localparam int MODE_BIT    = 3;       // interrupt mode select
    localparam int IE_BIT      = 0;       // interrupt enable
    localparam int KEEP_BIT    = 7;       // stored-only status bit
    localparam int FLAG_BIT    = 0;       // sticky expiry flag
endpackage

// File: rtl/alm_regfile.sv
// Module: alm_regfile
// Holds the seed bytes, control byte and status bits, and forms the
// interrupt request. Assumes one write strobe per cycle and that the
// expiry pulse comes from the counter in the same clock domain.
module alm_regfile
    import alarm_tmr_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int CNT_BYTES = 3,
    localparam int CNT_W    = CNT_BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic              wr_i,
    input  logic              expire_i,
    output logic [CNT_W-1:0]  seed_o,
    output logic              run_en_o,
    output logic              en_rise_o,
    output logic [BYTE_W-1:0] ctrl_o,
    output logic [BYTE_W-1:0] stat_o,
    output logic              irq_o
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);

    logic [BYTE_W-1:0] ctrl_q;
    logic              flag_q;
    logic              keep_q;
    logic              wr_ctrl;
    logic              wr_stat;
    logic [BYTE_W-1:0] seed_b [CNT_BYTES];

    assign wr_ctrl = wr_i && (addr_i == A_CTRL);
    assign wr_stat = wr_i && (addr_i == A_STAT);

    // One register per seed byte, each at its own address.
    for (genvar b = 0; b < CNT_BYTES; b++) begin : g_seed
        localparam logic [ADDR_W-1:0] A_BYTE = ADDR_W'(CNT_BASE + b);
        // Capture the written seed byte.
        always_ff @(posedge clk) begin
            if (!rst_n)
                seed_b[b] <= '0;
            else if (wr_i && (addr_i == A_BYTE))
                seed_b[b] <= wdata_i;
        end
        assign seed_o[BYTE_W*b +: BYTE_W] = seed_b[b];
    end

    // Store the writable control bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr_ctrl)
            ctrl_q <= wdata_i & CTRL_RW_MASK;
    end

    // Sticky flag: expiry sets it, a zero write clears it, expiry wins.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (expire_i)
            flag_q <= 1'b1;
        else if (wr_stat && !wdata_i[FLAG_BIT])
            flag_q <= 1'b0;
    end

    // Stored-only status bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            keep_q <= 1'b0;
        else if (wr_stat)
            keep_q <= wdata_i[KEEP_BIT];
    end

    // Assemble the status byte with fixed zeros.
    always_comb begin
        stat_o           = '0;
        stat_o[KEEP_BIT] = keep_q;
        stat_o[FLAG_BIT] = flag_q;
    end

    assign ctrl_o    = ctrl_q;
    assign run_en_o  = ctrl_q[EN_BIT];
    assign en_rise_o = wr_ctrl && wdata_i[EN_BIT] && !ctrl_q[EN_BIT];
    assign irq_o     = ctrl_q[IE_BIT] && ctrl_q[MODE_BIT] && flag_q;

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        expire_i |=> stat_o[FLAG_BIT]); // R6
    AST_FLAG_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_o[FLAG_BIT]) |-> $past(wr_stat && !wdata_i[FLAG_BIT])); // R6
    AST_SEED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(seed_o)); // R2
endmodule

// File: rtl/alm_countdown.sv
// Module: alm_countdown
// Live down-counter. It loads the seed when the enable rises, decrements
// on ticks while enabled with a nonzero seed, and reloads on expiry.
// Assumes tick_i is a single-cycle pulse.
module alm_countdown #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             run_en_i,
    input  logic             en_rise_i,
    input  logic [CNT_W-1:0] seed_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             expire_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             active;
    logic             step;

    assign active   = run_en_i && (seed_i != '0);
    assign step     = active && tick_i && !en_rise_i;
    assign expire_o = step && (cnt_q <= CNT_W'(1));
    assign cnt_o    = cnt_q;

    // Load on enable rise, reload on expiry, else count down on ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (en_rise_i || expire_o)
            cnt_q <= seed_i;
        else if (step)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    AST_LOAD_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        en_rise_i |=> (cnt_o == $past(seed_i))); // R4
    AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en_i && seed_i != '0 && tick_i && !en_rise_i && cnt_o > CNT_W'(1))
        |=> (cnt_o == $past(cnt_o) - CNT_W'(1))); // R3
    AST_FROZEN_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((!run_en_i || seed_i == '0 || !tick_i) && !en_rise_i) |=> $stable(cnt_o)); // R3
    AST_RELOAD_ON_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> (cnt_o == $past(seed_i))); // R5
endmodule

// File: rtl/alm_snapshot.sv
// Module: alm_snapshot
// Read path: snapshot register and registered read-data mux. A read of
// the lowest count byte returns live data and captures the full count.
// Upper count bytes come from the snapshot. Assumes one read per cycle.
module alm_snapshot
    import alarm_tmr_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int CNT_BYTES = 3,
    localparam int CNT_W    = CNT_BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [BYTE_W-1:0] ctrl_i,
    input  logic [BYTE_W-1:0] stat_i,
    output logic [BYTE_W-1:0] rdata_o
);
    localparam logic [ADDR_W-1:0] A_LOW  = ADDR_W'(CNT_BASE);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);

    logic [CNT_W-1:0]  hold_q;
    logic [BYTE_W-1:0] rdata_q;
    logic [BYTE_W-1:0] rd_sel;
    logic              snap;

    assign snap = rd_i && (addr_i == A_LOW);

    // Capture the live count when the lowest byte is read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_q <= '0;
        else if (snap)
            hold_q <= cnt_i;
    end

    // Select the byte addressed by the current read.
    always_comb begin
        rd_sel = '0;
        if (addr_i == A_LOW)
            rd_sel = cnt_i[BYTE_W-1:0];
        else if (addr_i == A_CTRL)
            rd_sel = ctrl_i;
        else if (addr_i == A_STAT)
            rd_sel = stat_i;
        for (int b = 1; b < CNT_BYTES; b++) begin
            if (addr_i == ADDR_W'(CNT_BASE + b))
                rd_sel = hold_q[BYTE_W*b +: BYTE_W];
        end
    end

    // Register read data on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (rd_i)
            rdata_q <= rd_sel;
    end

    assign rdata_o = rdata_q;

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !snap |=> $stable(hold_q)); // R8
    AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> $stable(rdata_o)); // R10
endmodule

// File: rtl/alarm_countdown_timer.sv
// Module: alarm_countdown_timer (top)
// Periodic reloading alarm behind a byte-wide register port. Ties the
// register file, live counter and read path together and drives the
// active-low interrupt. Assumes a single clock and synchronous reset.
module alarm_countdown_timer
    import alarm_tmr_pkg::*;
#(
    parameter int ADDR_W    = 5,
    parameter int CNT_BYTES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wdata_i,
    input  logic              wr_i,
    input  logic              rd_i,
    output logic [7:0]        rdata_o,
    output logic              int_n_o
);
    localparam int CNT_W = CNT_BYTES * BYTE_W;

    logic [CNT_W-1:0]  seed;
    logic [CNT_W-1:0]  cnt;
    logic              run_en;
    logic              en_rise;
    logic              expire;
    logic              irq;
    logic [BYTE_W-1:0] ctrl_b;
    logic [BYTE_W-1:0] stat_b;

    alm_regfile #(.ADDR_W(ADDR_W), .CNT_BYTES(CNT_BYTES)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wdata_i(wdata_i),
        .wr_i(wr_i), .expire_i(expire), .seed_o(seed), .run_en_o(run_en),
        .en_rise_o(en_rise), .ctrl_o(ctrl_b), .stat_o(stat_b), .irq_o(irq)
    );

    alm_countdown #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .run_en_i(run_en),
        .en_rise_i(en_rise), .seed_i(seed), .cnt_o(cnt), .expire_o(expire)
    );

    alm_snapshot #(.ADDR_W(ADDR_W), .CNT_BYTES(CNT_BYTES)) u_rd (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .rd_i(rd_i),
        .cnt_i(cnt), .ctrl_i(ctrl_b), .stat_i(stat_b), .rdata_o(rdata_o)
    );

    assign int_n_o = ~irq;

    AST_INT_LOW_AFTER_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && ctrl_b[IE_BIT] && ctrl_b[MODE_BIT] && !wr_i) |=> !int_n_o); // R7
endmodule

// File: tb/alarm_countdown_timer_tb_top.sv
`timescale 1ns/1ps
module alarm_countdown_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick_i;
    logic [4:0] addr_i;
    logic [7:0] wdata_i;
    logic       wr_i;
    logic       rd_i;
    logic [7:0] rdata_o;
    logic       int_n_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    string      q_tag[$];
    logic [7:0] q_exp[$];

    always #2.5 clk = ~clk;

    alarm_countdown_timer dut_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .wr_i(wr_i), .rd_i(rd_i),
        .rdata_o(rdata_o), .int_n_o(int_n_o)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        addr_i = a; wdata_i = d; wr_i = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_i = 1'b0;
    endtask

    task automatic wr_tick(input logic [4:0] a, input logic [7:0] d);
        addr_i = a; wdata_i = d; wr_i = 1'b1; tick_i = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_i = 1'b0; tick_i = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_i = 1'b1;
            @(posedge clk); @(negedge clk);
            tick_i = 1'b0;
        end
    endtask

    // Driver: queue the expected byte, then strobe the read.
    task automatic rd(input logic [4:0] a, input logic [7:0] exp, input string tag);
        q_tag.push_back(tag);
        q_exp.push_back(exp);
        addr_i = a; rd_i = 1'b1;
        @(posedge clk); @(negedge clk);
        rd_i = 1'b0;
    endtask

    // Monitor: a read sampled at a rising edge is compared at the next falling edge.
    initial begin
        forever begin
            logic pend;
            @(posedge clk);
            pend = rd_i;
            @(negedge clk);
            if (pend) begin
                if (q_exp.size() == 0) begin
                    n_tests++; n_fail++;
                    $display("FAIL R10 unexpected read result actual=%0h expected=none", rdata_o);
                end else begin
                    chk(q_tag.pop_front(), rdata_o, q_exp.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; tick_i = 1'b0; addr_i = '0; wdata_i = '0; wr_i = 1'b0; rd_i = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        chk("R1 int_n after reset", {7'b0, int_n_o}, 8'h01);
        rd(5'h04, 8'h00, "R1 count b0");
        rd(5'h05, 8'h00, "R1 count b1");
        rd(5'h06, 8'h00, "R1 count b2");
        rd(5'h07, 8'h00, "R1 ctrl");
        rd(5'h08, 8'h00, "R1 status");

        // R3 ticks with enable off; R2 seed write leaves count alone
        ticks(2);
        rd(5'h04, 8'h00, "R3 frozen while disabled");
        wr(5'h04, 8'h05); wr(5'h05, 8'h00); wr(5'h06, 8'h00);
        rd(5'h04, 8'h00, "R2 seed write keeps count");

        // R4 enable rise loads seed, R3 decrement
        wr(5'h07, 8'h49);
        rd(5'h04, 8'h05, "R4 load on enable rise");
        chk("R7 int_n idle", {7'b0, int_n_o}, 8'h01);
        ticks(1);
        rd(5'h04, 8'h04, "R3 decrement");
        ticks(3);
        rd(5'h04, 8'h01, "R3 count at one");
        rd(5'h08, 8'h00, "R6 flag clear before expiry");
        ticks(1);
        rd(5'h04, 8'h05, "R5 reload on expiry");
        rd(5'h08, 8'h01, "R6 flag set");
        chk("R7 int_n low", {7'b0, int_n_o}, 8'h00);

        // R6 write-1 no effect, write-0 clears
        wr(5'h08, 8'h01);
        rd(5'h08, 8'h01, "R6 write one ignored");
        chk("R7 int_n still low", {7'b0, int_n_o}, 8'h00);
        wr(5'h08, 8'h00);
        rd(5'h08, 8'h00, "R6 write zero clears");
        chk("R7 int_n released", {7'b0, int_n_o}, 8'h01);

        // R4 no reload when already enabled; R3 freeze on disable
        ticks(2);
        wr(5'h07, 8'h49);
        rd(5'h04, 8'h03, "R4 no reload while enabled");
        wr(5'h07, 8'h09);
        ticks(2);
        rd(5'h04, 8'h03, "R3 frozen after disable");
        wr(5'h07, 8'h49);
        rd(5'h04, 8'h05, "R4 reload on second rise");

        // R7 gating by mode bit
        wr(5'h07, 8'h41);
        ticks(5);
        rd(5'h08, 8'h01, "R5 second period expiry");
        chk("R7 int_n high with mode off", {7'b0, int_n_o}, 8'h01);
        wr(5'h07, 8'h49);
        chk("R7 int_n low with mode on", {7'b0, int_n_o}, 8'h00);

        // R6 expiry beats clearing write in the same cycle
        ticks(4);
        rd(5'h04, 8'h01, "R3 count at one again");
        wr_tick(5'h08, 8'h00);
        rd(5'h08, 8'h01, "R6 expiry wins over clear");
        rd(5'h04, 8'h05, "R5 reload with concurrent write");
        wr(5'h08, 8'h00);
        chk("R7 int_n high after clear", {7'b0, int_n_o}, 8'h01);

        // R3 zero seed keeps the counter idle
        wr(5'h04, 8'h00);
        wr(5'h07, 8'h09); wr(5'h07, 8'h49);
        ticks(3);
        rd(5'h04, 8'h00, "R3 zero seed idle");
        rd(5'h08, 8'h00, "R3 no expiry on zero seed");

        // R8 coherent multi-byte read
        wr(5'h04, 8'h03); wr(5'h05, 8'h01); wr(5'h06, 8'h12);
        wr(5'h07, 8'h09); wr(5'h07, 8'h49);
        ticks(3);
        rd(5'h04, 8'h00, "R8 low byte live");
        ticks(1);
        rd(5'h05, 8'h01, "R8 mid byte from snapshot");
        rd(5'h06, 8'h12, "R8 high byte from snapshot");
        rd(5'h04, 8'hFF, "R8 new snapshot low");
        rd(5'h05, 8'h00, "R8 new snapshot mid");

        // R9 fixed-zero bits and stored-only bits
        wr(5'h07, 8'hFF);
        rd(5'h07, 8'hCF, "R9 ctrl readback");
        chk("R9 int_n with flag clear", {7'b0, int_n_o}, 8'h01);
        wr(5'h08, 8'h81);
        rd(5'h08, 8'h80, "R9 status bit7 stored");
        wr(5'h08, 8'h7E);
        rd(5'h08, 8'h00, "R9 status middle bits zero");
        ticks(1);
        rd(5'h04, 8'hFE, "R9 extra ctrl bits no effect");

        // R10 read data holds between reads
        repeat (3) @(negedge clk);
        chk("R10 rdata holds", rdata_o, 8'hFE);

        // R1 reset mid-run clears everything including the seed
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 int_n after second reset", {7'b0, int_n_o}, 8'h01);
        rd(5'h07, 8'h00, "R1 ctrl after second reset");
        wr(5'h07, 8'h40);
        rd(5'h04, 8'h00, "R1 seed cleared");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule